// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Controller

This block is the bus-facing half of a small two-wire (I2C) serial memory. It oversamples the SCL and SDA lines with the system clock and filters out short glitches. It detects START and STOP conditions and answers a single fixed device address. A neighbouring page-buffer block owns the 256-byte array. This controller hands that block one load strobe per accepted data byte, a commit strobe when STOP closes a write, and a reject strobe when a write is abandoned. Reads use a combinational array read port.

The controller runs byte writes and page writes. Within a write, the byte address wraps inside its 16-byte page. It also runs current-address reads, selective reads (a write header and an address byte, then a repeated START and a read header) and sequential reads, which wrap from the top of the array back to zero. SDA is driven only as an open-drain pull-low enable.

While the buffer block reports its internal write cycle as busy, the device address gets no acknowledge, so a master can poll for completion. A write-protect level is captured at one defined SCL edge. If it is high there, the first data byte is refused and the write is rejected.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_pull_o`, `ld_valid_o`, `commit_o` and `reject_o` are all low.
- R2: START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. The first byte after START is seven address bits, MSB first, then an R/W bit in bit 0 (1 = read). Only address 7'b1010000 (header bytes 8'hA0 write, 8'hA1 read) is acknowledged. Any other header gets no acknowledge and the transfer is ignored until the next START or STOP.
- R3: Input bits are taken on the SCL rise. An acknowledge is driven low during the 9th SCL clock of an accepted byte and released after that clock's falling edge. Read data bits change only while SCL is low and stay stable while SCL is high.
- R4: While `busy_i` is high, the device header gets no acknowledge.
- R5: A write is a header, an address byte, then one or more data bytes, each acknowledged. Each data byte gives one `ld_valid_o` pulse carrying its address and data. The address advances in bits [3:0] only and wraps within the 16-byte page. STOP after at least one load pulses `commit_o` once.
- R6: `wp_i` is captured on the SCL fall that ends the acknowledge clock of the address byte. If it is high there, the first data byte gets no acknowledge, `reject_o` pulses, and no load or commit follows. Changes of `wp_i` after that edge have no effect on the write.
- R7: A read header with no preceding address returns the byte at the internal address. After any read byte, the internal address points one past that byte. After a write, it points one past the last loaded byte, within the page.
- R8: In a selective read, the address byte sent after a write header selects the first byte returned after the repeated START and read header.
- R9: In a read, a master acknowledge fetches the next byte, with the address wrapping from 8'hFF to 8'h00. A master no-acknowledge followed by STOP returns the controller to idle with SDA released.
- R10: A pulse of one system clock on SCL or SDA has no effect on the transfer.
- R11: A repeated START after at least one load, with no STOP between, pulses `reject_o` and issues no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When high, pull SDA low (open-drain enable) |
| wp_i | input | 1 | Write-protect level |
| busy_i | input | 1 | Buffer block internal write cycle in progress |
| rd_data_i | input | 8 | Array byte at `rd_addr_o` |
| rd_addr_o | output | 8 | Array read address (internal address register) |
| ld_valid_o | output | 1 | Load strobe toward the page buffer |
| ld_addr_o | output | 8 | Address of the loaded byte |
| ld_data_o | output | 8 | Loaded byte |
| commit_o | output | 1 | Start the internal write cycle (STOP after loads) |
| reject_o | output | 1 | Discard loaded bytes |

## Verification
The bench writes pages that start near the top of a page and run past 16 bytes. A design that carried the increment into the upper address bits would corrupt the next page, and the readback would show it. It polls right after STOP and expects a refused header, which catches a design that ignores busy. It raises write-protect both before and after the capture edge, which catches a design that samples the level at the wrong edge or keeps sampling it. Sequential reads across 8'hFF, current-address reads after both reads and writes, a repeated START that abandons loaded bytes, and one-clock glitches on both lines each catch a specific slip: a lost wrap, a stale address pointer, a spurious commit, or a false START/STOP or extra bit.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int unsigned NUM_LINES = 2;  // index 0: SCL, 1: SDA

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_RACK,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/i2c_glitch_filt.sv
module i2c_glitch_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TAPS        = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned HALF = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        taps_q;
  logic                   out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      taps_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      taps_q <= {taps_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      out_q  <= ($countones(taps_q) > HALF);
    end
  end

  assign line_o = out_q;

  // R10: the filtered level never moves against a unanimous tap window
  p_filt_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(taps_q) == '0) |-> !out_q);
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 16,
  parameter logic [6:0]  DEV_ADDR   = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sda_pull_o,
  output logic              ld_valid_o,
  output logic [ADDR_W-1:0] ld_addr_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              commit_o,
  output logic              reject_o
);
  localparam int unsigned PW = $clog2(PAGE_BYTES);
  localparam int unsigned CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  st_e               st_q, nxt_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q, ld_addr_q;
  logic [DATA_W-1:0] ld_data_q;
  logic pull_q, wp_q, first_q, pend_q, mack_q;
  logic ld_q, commit_q, reject_q;

  // increment that stays inside the current page
  function automatic logic [ADDR_W-1:0] pg_inc(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a;
    r[PW-1:0] = a[PW-1:0] + 1'b1;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      ld_addr_q <= '0;
      ld_data_q <= '0;
      pull_q    <= 1'b0;
      wp_q      <= 1'b0;
      first_q   <= 1'b0;
      pend_q    <= 1'b0;
      mack_q    <= 1'b0;
      ld_q      <= 1'b0;
      commit_q  <= 1'b0;
      reject_q  <= 1'b0;
    end else begin
      ld_q     <= 1'b0;
      commit_q <= 1'b0;
      reject_q <= 1'b0;
      if (start_i) begin
        st_q     <= ST_DEV;
        cnt_q    <= '0;
        pull_q   <= 1'b0;
        reject_q <= pend_q;
        pend_q   <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        pull_q   <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else if (scl_rise_i) begin
        case (st_q)
          ST_DEV, ST_ADDR, ST_WDAT:
            if (cnt_q != FULL) begin
              sh_q  <= {sh_q[DATA_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end
          ST_RACK: mack_q <= ~sda_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (st_q)
          ST_DEV:
            if (cnt_q == FULL) begin
              cnt_q <= '0;
              if (sh_q[DATA_W-1:1] == DEV_ADDR && !busy_i) begin
                pull_q <= 1'b1;
                st_q   <= ST_ACK;
                nxt_q  <= sh_q[0] ? ST_RDAT : ST_ADDR;
              end else begin
                st_q <= ST_WAIT;
              end
            end
          ST_ADDR:
            if (cnt_q == FULL) begin
              cnt_q   <= '0;
              addr_q  <= sh_q;
              pull_q  <= 1'b1;
              st_q    <= ST_ACK;
              nxt_q   <= ST_WDAT;
              first_q <= 1'b1;
            end
          ST_WDAT:
            if (cnt_q == FULL) begin
              cnt_q <= '0;
              if (first_q && wp_q) begin
                reject_q <= 1'b1;
                st_q     <= ST_WAIT;
              end else begin
                pull_q    <= 1'b1;
                st_q      <= ST_ACK;
                nxt_q     <= ST_WDAT;
                ld_q      <= 1'b1;
                ld_addr_q <= addr_q;
                ld_data_q <= sh_q;
                addr_q    <= pg_inc(addr_q);
                pend_q    <= 1'b1;
                first_q   <= 1'b0;
              end
            end
          ST_ACK: begin
            st_q <= nxt_q;
            if (nxt_q == ST_WDAT && first_q) wp_q <= wp_i;  // protect strobe
            if (nxt_q == ST_RDAT) begin
              sh_q   <= rd_data_i;
              pull_q <= ~rd_data_i[DATA_W-1];
              cnt_q  <= CW'(1);
              addr_q <= addr_q + 1'b1;
            end else begin
              pull_q <= 1'b0;
            end
          end
          ST_RDAT:
            if (cnt_q == FULL) begin
              pull_q <= 1'b0;
              st_q   <= ST_RACK;
            end else begin
              pull_q <= ~sh_q[DATA_W-2];
              sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
              cnt_q  <= cnt_q + 1'b1;
            end
          ST_RACK:
            if (mack_q) begin
              sh_q   <= rd_data_i;
              pull_q <= ~rd_data_i[DATA_W-1];
              cnt_q  <= CW'(1);
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_RDAT;
            end else begin
              st_q <= ST_WAIT;
            end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign sda_pull_o = pull_q;
  assign ld_valid_o = ld_q;
  assign ld_addr_o  = ld_addr_q;
  assign ld_data_o  = ld_data_q;
  assign commit_o   = commit_q;
  assign reject_o   = reject_q;

  // R4: a busy array never sees its header acknowledged
  p_busy_nack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && st_q == ST_DEV && cnt_q == FULL && busy_i) |=> !sda_pull_o);

  // R3: SDA drive only moves while SCL is low
  p_pull_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_lvl_i);

  // R9: STOP leaves the bus released and the controller idle
  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (st_q == ST_IDLE && !sda_pull_o));

  // R9: a continued read fetches the following address, wrapping at the top
  p_rd_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RDAT && $past(st_q) == ST_RACK) |->
      rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1));

  // R5: commit and loads never coincide
  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !ld_valid_o && !reject_o);
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PAGE_BYTES  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TAPS   = 3,
  parameter logic [6:0]  DEV_ADDR    = 7'h50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              ld_valid_o,
  output logic [ADDR_W-1:0] ld_addr_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              commit_o,
  output logic              reject_o
);
  logic [NUM_LINES-1:0] raw, flt;
  logic scl_rise, scl_fall, start, stop;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_filt
    i2c_glitch_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(flt[g])
    );
  end

  i2c_bus_events u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (flt[0]),
    .sda_i     (flt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  i2c_mem_fsm #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES),
    .DEV_ADDR  (DEV_ADDR)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_lvl_i (flt[0]),
    .sda_i     (flt[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start),
    .stop_i    (stop),
    .wp_i      (wp_i),
    .busy_i    (busy_i),
    .rd_data_i (rd_data_i),
    .rd_addr_o (rd_addr_o),
    .sda_pull_o(sda_pull_o),
    .ld_valid_o(ld_valid_o),
    .ld_addr_o (ld_addr_o),
    .ld_data_o (ld_data_o),
    .commit_o  (commit_o),
    .reject_o  (reject_o)
  );

  // R1: reset leaves the bus released and all strobes quiet
  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!sda_pull_o && !ld_valid_o && !commit_o && !reject_o);
    end
  end
endmodule

// File: tb/i2c_mem_target_tb_top.sv
module i2c_mem_target_tb_top;
  localparam int Q        = 8;    // quarter SCL period in system clocks
  localparam int BUSY_CYC = 600;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, wp_m;
  logic sda_bus;
  logic sda_pull_o, ld_valid_o, commit_o, reject_o, busy;
  logic [7:0] rd_addr_o, ld_addr_o, ld_data_o, rd_data;

  logic [7:0] mem [0:255];
  logic [7:0] pbuf[0:255];
  logic       pv  [0:255];
  logic [7:0] exp_mem[0:255];
  logic [7:0] wdat[0:31];
  logic [7:0] exp_ptr;
  int busy_cnt = 0, commit_seen = 0, rej_seen = 0;
  int nvec = 0, nerr = 0;
  bit glitch_en = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_o;
  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr_o];

  i2c_mem_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .wp_i(wp_m), .busy_i(busy),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr_o),
    .ld_valid_o(ld_valid_o), .ld_addr_o(ld_addr_o), .ld_data_o(ld_data_o),
    .commit_o(commit_o), .reject_o(reject_o)
  );

  // page buffer stand-in
  always @(posedge clk) begin
    if (ld_valid_o) begin
      pbuf[ld_addr_o] <= ld_data_o;
      pv[ld_addr_o]   <= 1'b1;
    end
    if (commit_o) begin
      busy_cnt    <= BUSY_CYC;
      commit_seen <= commit_seen + 1;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (reject_o) begin
      rej_seen <= rej_seen + 1;
      for (int i = 0; i < 256; i++) pv[i] <= 1'b0;
    end
    if (busy_cnt == 1)
      for (int i = 0; i < 256; i++) begin
        if (pv[i]) mem[i] <= pbuf[i];
        pv[i] <= 1'b0;
      end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (glitch_en) begin
        sda_m = ~b[i]; tick(1);
        sda_m = b[i];  tick(Q - 1);
      end else tick(Q);
      scl_m = 1'b0;
      if (glitch_en) begin
        tick(Q / 2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q / 2 - 1);
      end else tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    logic s1, s2;
    bit stable = 1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(1);
      s1 = sda_bus; tick(2 * Q - 2);
      s2 = sda_bus; tick(1);
      if (s1 !== s2) stable = 0;
      b[i] = s1;
      scl_m = 1'b0; tick(Q);
    end
    chk("R3 read bit stable while SCL high", int'(stable), 1);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic poll(output int tries);
    bit ack;
    tries = 0;
    do begin
      tries++;
      bus_start; wr_byte(8'hA0, ack); bus_stop;
    end while (!ack && tries < 100);
  endtask

  function automatic logic [7:0] pg_addr(input logic [7:0] a, input int k);
    return (a & 8'hF0) | ((a + 8'(k)) & 8'h0F);
  endfunction

  task automatic wr_seq(input logic [7:0] a, input int n, input logic wp_hdr,
                        input logic wp_dat, input bit ok);
    bit ack;
    int tries, c0, r0;
    c0 = commit_seen; r0 = rej_seen;
    wp_m = wp_hdr;
    bus_start;
    wr_byte(8'hA0, ack); chk("R2 write header ack", int'(ack), 1);
    wr_byte(a, ack);     chk("R5 address byte ack", int'(ack), 1);
    wp_m = wp_dat;
    for (int k = 0; k < n; k++) begin
      wr_byte(wdat[k], ack);
      if (!ok && k == 0) chk("R6 protected data byte nack", int'(ack), 0);
      if (ok) begin
        chk("R5 data byte ack", int'(ack), 1);
        chk("R3 ack released after 9th clock", int'(sda_pull_o), 0);
      end
    end
    bus_stop;
    wp_m = 1'b0;
    if (ok) begin
      for (int k = 0; k < n; k++) exp_mem[pg_addr(a, k)] = wdat[k];
      exp_ptr = pg_addr(a, n);
    end
    poll(tries);
    if (ok) begin
      chk("R5 one commit per write", commit_seen - c0, 1);
      chk("R4 header refused while busy", int'(tries > 1), 1);
      chk("R4 header accepted once idle", int'(tries < 100), 1);
    end else begin
      chk("R6 reject strobe", rej_seen - r0, 1);
      chk("R6 no commit after reject", commit_seen - c0, 0);
      chk("R6 no write cycle started", tries, 1);
    end
  endtask

  task automatic sel_read(input logic [7:0] a, input int n);
    bit ack;
    logic [7:0] b;
    bus_start;
    wr_byte(8'hA0, ack);
    wr_byte(a, ack);
    bus_start;
    wr_byte(8'hA1, ack); chk("R8 read header ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k < n - 1, b);
      chk("R8 R9 read data", b, exp_mem[8'(a + 8'(k))]);
    end
    bus_stop;
    exp_ptr = 8'(a + 8'(n));
  endtask

  task automatic cur_read(input int n);
    bit ack;
    logic [7:0] b;
    bus_start;
    wr_byte(8'hA1, ack); chk("R7 read header ack", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k < n - 1, b);
      chk("R7 current address data", b, exp_mem[8'(exp_ptr + 8'(k))]);
    end
    bus_stop;
    exp_ptr = 8'(exp_ptr + 8'(n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    bit ack;
    int c0, r0;
    logic [7:0] b, a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5; exp_mem[i] = 8'(i) ^ 8'hA5; pv[i] = 1'b0; pbuf[i] = 8'h00;
    end
    exp_ptr = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp_m = 1'b0;
    tick(5);
    chk("R1 pull low after reset", int'(sda_pull_o), 0);
    chk("R1 strobes quiet after reset", int'({ld_valid_o, commit_o, reject_o}), 0);
    rst_n = 1'b1;
    tick(4);

    // R2: foreign headers are refused
    bus_start; wr_byte(8'hA2, ack); chk("R2 foreign address nack", int'(ack), 0); bus_stop;
    bus_start; wr_byte(8'h21, ack); chk("R2 foreign address nack", int'(ack), 0); bus_stop;
    chk("R2 no strobes after foreign address", commit_seen + rej_seen, 0);

    // R7: current read from reset address 0
    cur_read(2);

    // R5: byte write, then page write wrapping inside the page
    wdat[0] = 8'h3C;
    wr_seq(8'h10, 1, 1'b0, 1'b0, 1'b1);
    cur_read(1);                       // R7: one past the written byte
    for (int k = 0; k < 18; k++) wdat[k] = 8'(8'h80 + k);
    wr_seq(8'h2E, 18, 1'b0, 1'b0, 1'b1);
    sel_read(8'h20, 16);
    sel_read(8'h30, 2);                // R5: next page untouched
    sel_read(8'h1F, 1);                // R5: previous page untouched

    // R6: protected at the capture edge
    wdat[0] = 8'h11;
    wr_seq(8'h50, 1, 1'b1, 1'b1, 1'b0);
    sel_read(8'h50, 1);
    // R6: raised after the capture edge has no effect
    wdat[0] = 8'h22; wdat[1] = 8'h33;
    wr_seq(8'h60, 2, 1'b0, 1'b1, 1'b1);
    sel_read(8'h60, 2);

    // R9: sequential read across the top of the array
    sel_read(8'hFD, 5);
    cur_read(1);

    // R11: repeated START abandons loaded bytes
    c0 = commit_seen; r0 = rej_seen;
    bus_start; wr_byte(8'hA0, ack); wr_byte(8'h40, ack); wr_byte(8'h77, ack);
    bus_start; wr_byte(8'hA1, ack);
    rd_byte(1'b0, b);
    chk("R11 read after abandon uses next address", b, exp_mem[8'h41]);
    bus_stop;
    chk("R11 reject on repeated start", rej_seen - r0, 1);
    chk("R11 no commit", commit_seen - c0, 0);
    sel_read(8'h40, 1);

    // R10: one-clock glitches on both lines
    glitch_en = 1;
    for (int k = 0; k < 4; k++) wdat[k] = 8'(8'hC0 ^ (k * 8'h13));
    wr_seq(8'h84, 4, 1'b0, 1'b0, 1'b1);
    glitch_en = 0;
    sel_read(8'h84, 4);

    // random mix
    for (int it = 0; it < 6; it++) begin
      int n;
      a = 8'($urandom % 256);
      n = 1 + int'($urandom % 20);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      wr_seq(a, n, 1'b0, 1'b0, 1'b1);
      sel_read(8'($urandom % 256), 1 + int'($urandom % 6));
      cur_read(1 + int'($urandom % 3));
    end

    tick(20);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule